// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A watchdog counter on a small word-wide register port. Software picks one of sixteen power-of-two periods, enables the counter, and must then write a fixed key to the restart register before the count runs out. If the count does run out, the block either pulses a system reset at once or, in interrupt mode, first raises an interrupt and counts a second period. Only if that second period also expires with no restart does it pulse the reset.

Two period selectors are held. The start selector sets the first period after enable. The reload selector sets every later period, after a restart or after the first stage of interrupt mode. Once enabled, the watchdog cannot be disabled by software. After the reset pulse the counter stays frozen until the block's own reset.

The port is single-cycle. A request with `we_i` high writes on the clock edge. A request with `we_i` low returns its data on `rdata_o` after that edge, and the data is held until the next read.

Top module: `wdog_timer`

## Requirements
- R1: The enable bit (bit 0 of offset 0x00) can be set by software but not cleared; a write of 0 leaves it reading 1 until rst_ni.
- R2: When enabled, the counter loads 2^(BASE_EXP+s)-1 for start selector s (bits [7:4] of offset 0x04). The timeout acts 2^(BASE_EXP+s)+1 cycles after the edge that writes the enable.
- R3: A write of exactly 0x76 to offset 0x0C reloads the counter from the reload selector (bits [3:0] of offset 0x04) and drops the interrupt. Any other value written there has no effect.
- R4: With mode bit (bit 1 of offset 0x00) at 0, a timeout raises sys_rst_o.
- R5: With mode bit 1, the first timeout raises irq_o and reloads the counter from the reload selector. A later timeout with the interrupt still pending raises sys_rst_o.
- R6: irq_o stays high until a valid restart, a read of offset 0x14, or the reset pulse. The read of 0x14 returns 0 and does not reload the counter.
- R7: sys_rst_o stays high for exactly PULSE_LEN cycles. After that the counter is frozen and the pulse never repeats until rst_ni.
- R8: Reads return {mode,enable} at 0x00, the selectors at 0x04, the interrupt at bit 0 of 0x10, and 0x40 at 0xF4. Unmapped offsets read 0. Writes to 0x08, 0x10 and 0xF4 have no effect.
- R9: While counting, the value at 0x08 falls by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous block reset |
| req_i | input | 1 | Access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid after the read edge |
| irq_o | output | 1 | First-stage timeout interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The assertions assume that the port inputs are stable across each clock edge and that a request lasts one cycle. They also assume that `rst_ni` is applied before any access. The bench drives every access at the falling edge and drops `req_i` at the next falling edge, so no request straddles two rising edges. The bench reapplies `rst_ni` before each scenario because the reset pulse leaves the counter frozen. Random selectors stay in 0..3 and restart gaps stay shorter than the reload period, so every period fits in a short run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W = 4;
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_SEL   = 8'h04;
  localparam logic [7:0] OFF_CNT   = 8'h08;
  localparam logic [7:0] OFF_KICK  = 8'h0C;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_ICLR  = 8'h14;
  localparam logic [7:0] OFF_PARAM = 8'hF4;
  localparam logic [31:0] KICK_KEY  = 32'h0000_0076;
  localparam logic [31:0] PARAM_VAL = 32'h0000_0040;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PULSE, ST_DEAD} wd_state_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             irq_i,
  output logic             en_o,
  output logic             mode_o,
  output logic [SEL_W-1:0] sel_init_o,
  output logic [SEL_W-1:0] sel_run_o,
  output logic             kick_o,
  output logic             irq_clr_o
);
  logic wr, rd;
  logic en_q, mode_q;
  logic [2*SEL_W-1:0] sel_q;
  logic [31:0] rd_mux, rdata_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      sel_q  <= '0;
    end else if (wr) begin
      if (addr_i == OFF_CTRL) begin
        en_q   <= en_q | wdata_i[0];  // set-only
        mode_q <= wdata_i[1];
      end
      if (addr_i == OFF_SEL) sel_q <= wdata_i[2*SEL_W-1:0];
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_CTRL:  rd_mux = {30'b0, mode_q, en_q};
      OFF_SEL:   rd_mux = {{(32-2*SEL_W){1'b0}}, sel_q};
      OFF_CNT:   rd_mux = 32'(cnt_i);
      OFF_STAT:  rd_mux = {31'b0, irq_i};
      OFF_PARAM: rd_mux = PARAM_VAL;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o    = rdata_q;
  assign en_o       = en_q;
  assign mode_o     = mode_q;
  assign sel_run_o  = sel_q[SEL_W-1:0];
  assign sel_init_o = sel_q[2*SEL_W-1:SEL_W];
  assign kick_o     = wr && addr_i == OFF_KICK && wdata_i == KICK_KEY;
  assign irq_clr_o  = rd && addr_i == OFF_ICLR;

  // R1
  en_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int BASE_EXP  = 16,
  parameter int PULSE_LEN = 8,
  localparam int NUM_SEL = 1 << SEL_W,
  localparam int CNT_W   = BASE_EXP + NUM_SEL - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic [SEL_W-1:0] sel_init_i,
  input  logic [SEL_W-1:0] sel_run_i,
  input  logic             kick_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             sys_rst_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  wd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    pcnt_q;
  logic             irq_q, irq_pend;

  function automatic logic [CNT_W-1:0] top_val(input logic [SEL_W-1:0] s);
    return {CNT_W{1'b1}} >> (NUM_SEL - 1 - int'(s));
  endfunction

  assign irq_pend = irq_q & ~irq_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pcnt_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (en_i) begin
          cnt_q   <= top_val(sel_init_i);
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (kick_i) begin
            cnt_q <= top_val(sel_run_i);
            irq_q <= 1'b0;
          end else if (cnt_q == '0) begin
            if (!mode_i || irq_pend) begin
              state_q <= ST_PULSE;
              pcnt_q  <= PW'(PULSE_LEN - 1);
              irq_q   <= 1'b0;
            end else begin
              irq_q <= 1'b1;
              cnt_q <= top_val(sel_run_i);
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
            irq_q <= irq_pend;
          end
        end
        ST_PULSE: begin
          if (pcnt_q == '0) state_q <= ST_DEAD;
          else              pcnt_q  <= pcnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign cnt_o     = cnt_q;
  assign irq_o     = irq_q;
  assign sys_rst_o = (state_q == ST_PULSE);

  // R9
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !kick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R4
  rst_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !mode_i && !kick_i && cnt_q == '0) |=> sys_rst_o);
  // R3
  kick_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && kick_i) |=> !irq_o);
  // R6
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && state_q == ST_RUN && !kick_i && !irq_clr_i && cnt_q != '0) |=> irq_o);
  // R7
  dead_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEAD) |=> (state_q == ST_DEAD && !sys_rst_o && $stable(cnt_q)));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int BASE_EXP  = 16,
  parameter int PULSE_LEN = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        sys_rst_o
);
  localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1;

  logic             en, mode, kick, irq_clr;
  logic [SEL_W-1:0] sel_init, sel_run;
  logic [CNT_W-1:0] cnt;

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .irq_i(irq_o), .en_o(en), .mode_o(mode),
    .sel_init_o(sel_init), .sel_run_o(sel_run), .kick_o(kick), .irq_clr_o(irq_clr)
  );

  wdog_core #(.BASE_EXP(BASE_EXP), .PULSE_LEN(PULSE_LEN)) u_core (
    .clk_i, .rst_ni, .en_i(en), .mode_i(mode), .sel_init_i(sel_init),
    .sel_run_i(sel_run), .kick_i(kick), .irq_clr_i(irq_clr),
    .cnt_o(cnt), .irq_o, .sys_rst_o
  );
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int BASE = 4;
  localparam int PLEN = 8;

  logic clk = 1'b0, rst_ni = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, sys_rst;
  int n_run = 0, n_fail = 0;
  logic seen_rst = 1'b0;

  always #2 clk = ~clk;

  wdog_timer #(.BASE_EXP(BASE), .PULSE_LEN(PLEN)) u_wdog_timer (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sys_rst_o(sys_rst)
  );

  always @(posedge clk) if (sys_rst) seen_rst <= 1'b1;

  function automatic int per(input int s);
    return 1 << (BASE + s);
  endfunction

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; req = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1; seen_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    req = 1'b0; d = rdata;
  endtask

  task automatic wait_rst(output int n);
    n = 0;
    while (!sys_rst && n < 100000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && !sys_rst && n < 100000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    int n;
    void'($urandom(32'd4242));
    do_reset();

    // reset state and register map (R8)
    check("R8 irq reset", {31'b0, irq}, 0);
    check("R8 rst reset", {31'b0, sys_rst}, 0);
    bus_rd(8'h00, d); check("R8 ctrl reset", d, 0);
    bus_rd(8'hF4, d); check("R8 param", d, 32'h40);
    bus_wr(8'hF4, 32'h0); bus_rd(8'hF4, d); check("R8 param ro", d, 32'h40);
    bus_wr(8'h10, 32'h1); bus_rd(8'h10, d); check("R8 stat ro", d, 0);
    bus_wr(8'h08, 32'h55); bus_rd(8'h08, d); check("R8 cnt ro", d, 0);
    bus_rd(8'h20, d); check("R8 unmapped", d, 0);
    bus_wr(8'h04, 32'hA5); bus_rd(8'h04, d); check("R8 sel rb", d, 32'hA5);
    bus_wr(8'h00, 32'h2); bus_rd(8'h00, d); check("R8 ctrl rb", d, 32'h2);
    bus_wr(8'h0C, 32'h76); bus_rd(8'h08, d); check("R3 kick before enable", d, 0);

    // reset mode timeout and pulse (R2 R4 R7)
    do_reset();
    bus_wr(8'h04, 32'h21);
    bus_wr(8'h00, 32'h1);
    wait_rst(n); check("R2 R4 first timeout", n, per(2) + 1);
    n = 0;
    while (sys_rst && n < 1000) begin @(negedge clk); n++; end
    check("R7 pulse width", n, PLEN);
    bus_rd(8'h08, d);
    seen_rst = 1'b0;
    repeat (50) @(negedge clk);
    bus_rd(8'h08, d2);
    check("R7 frozen", d2, d);
    check("R7 no repeat", {31'b0, seen_rst}, 0);

    // lock, restarts, bad key, count (R1 R3 R9)
    do_reset();
    bus_wr(8'h04, 32'h21);
    bus_wr(8'h00, 32'h1);
    bus_wr(8'h00, 32'h0);
    bus_rd(8'h00, d); check("R1 enable lock", d[0], 1);
    for (int i = 0; i < 15; i++) begin
      repeat ($urandom_range(0, 20)) @(negedge clk);
      bus_wr(8'h0C, 32'h76);
    end
    check("R3 restarts hold off reset", {31'b0, seen_rst}, 0);
    bus_wr(8'h0C, 32'h76);
    bus_rd(8'h08, d); check("R9 count after kick", d, per(1) - 1);
    bus_rd(8'h08, d); check("R9 count falls", d, per(1) - 2);
    bus_wr(8'h0C, 32'h75);
    wait_rst(n); check("R3 bad key ignored", n, per(1) - 3);

    // two-stage response (R5)
    do_reset();
    bus_wr(8'h04, 32'h10);
    bus_wr(8'h00, 32'h3);
    wait_irq(n); check("R5 first stage irq", n, per(1) + 1);
    check("R5 no reset at stage 1", {31'b0, sys_rst}, 0);
    bus_rd(8'h10, d); check("R8 stat set", d, 1);
    wait_rst(n); check("R5 second stage reset", n, per(0) - 1);
    check("R6 irq dropped by reset", {31'b0, irq}, 0);

    // interrupt clear and restart (R6 R3)
    do_reset();
    bus_wr(8'h04, 32'h10);
    bus_wr(8'h00, 32'h3);
    wait_irq(n);
    bus_rd(8'h14, d); check("R6 clear reads 0", d, 0);
    check("R6 irq cleared", {31'b0, irq}, 0);
    bus_rd(8'h08, d); check("R6 no reload on clear", d, per(0) - 2);
    wait_irq(n); check("R6 irq again", n, per(0) - 2);
    check("R6 no reset after clear", {31'b0, sys_rst}, 0);
    bus_wr(8'h0C, 32'h76);
    check("R3 kick drops irq", {31'b0, irq}, 0);
    bus_rd(8'h10, d); check("R3 stat after kick", d, 0);

    // constrained random selectors and modes (R2 R4 R5)
    for (int i = 0; i < 10; i++) begin
      int si, sr, md;
      si = $urandom_range(0, 3); sr = $urandom_range(0, 3); md = $urandom_range(0, 1);
      do_reset();
      bus_wr(8'h04, 32'((si << 4) | sr));
      bus_wr(8'h00, 32'((md << 1) | 1));
      if (md == 1) begin
        wait_irq(n); check("R5 rand stage 1", n, per(si) + 1);
        check("R5 rand irq", {31'b0, irq}, 1);
        wait_rst(n); check("R5 rand stage 2", n, per(sr));
      end else begin
        wait_rst(n); check("R4 rand timeout", n, per(si) + 1);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule